// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block paces a dual-slope measurement by counting clock edges. Each conversion has three parts. First the integrator is zeroed for a fixed span. Next the unknown input is integrated for a second fixed span. Last the reference is integrated until the comparator reports a zero crossing. The number of clocks spent in that last part is the conversion result. It is captured and presented together with an over-range flag and an under-range flag.

The reference window always has its full length. Clocks that remain after the crossing are spent with the integrator zeroed, so every conversion takes exactly the same number of clocks. A level input selects the mode. Held high, it makes conversions follow one another with no gap. Held low, it lets the current conversion finish and then parks the sequencer with the result frozen. A high pulse while parked launches one more conversion. The comparator is modelled as a single digital flag. It can pass through an optional chain of synchronising flops.

Top module: `dsc_sequencer`

## Requirements
- R1: After reset the sequencer is parked: `az_sel`=1, `si_sel`=0, `ri_sel`=0, `busy`=0, `eom`=0, `ref_count`=0, and both range flags are 0. Exactly one of the three phase selects is high in every cycle.
- R2: A conversion opens with `AZ_LEN` clocks (default 10001) in which `az_sel`=1 and `busy`=0.
- R3: Exactly `SI_LEN` clocks (default 10000) with `si_sel`=1 and `busy`=1 follow. A high comparator flag seen outside the reference phase has no effect on phase lengths or on the result.
- R4: Number the reference clocks from 0. `ri_sel` is high from clock 0 up to and including clock k, where k is the first clock at whose closing edge the comparator flag (after `ZC_SYNC` flops) is high. The result is k.
- R5: After the crossing and until the window of `RI_MAX` clocks (default 20001) closes, `az_sel`=1 and `busy`=1.
- R6: In the clock right after the window closes, `eom`=1 for exactly one cycle and `busy`=0. `ref_count` and both flags change only at that point and hold their value until the next such point.
- R7: If no crossing occurs within the window, `ref_count`=`RI_MAX`, `over_flag`=1 and `under_flag`=0.
- R8: `under_flag`=1 exactly when there is no over-range and the result is strictly less than `under_th`.
- R9: When `run_hold`=1 at the closing edge of the window, the next conversion's zeroing phase starts at once. The period is `AZ_LEN+SI_LEN+RI_MAX` clocks (default 40002).
- R10: When `run_hold`=0 at the closing edge, the sequencer parks: `az_sel`=1, `busy`=0, and the result is unchanged for as long as `run_hold` stays 0.
- R11: While parked, a `run_hold` level of 1 seen at a clock edge starts a conversion whose zeroing phase begins in the next clock. Pulses on `run_hold` during a conversion are not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| run_hold | input | 1 | 1 = run continuously; 0 = park after the current conversion; pulse = one conversion |
| zc_in | input | 1 | Comparator zero-crossing flag, active high |
| under_th | input | CW | Under-range threshold, compared against the result |
| az_sel | output | 1 | Integrator zeroing phase select |
| si_sel | output | 1 | Signal integration phase select |
| ri_sel | output | 1 | Reference integration phase select |
| busy | output | 1 | High from the end of zeroing until the window closes |
| eom | output | 1 | One-clock end-of-measurement pulse |
| ref_count | output | CW | Latched reference-phase clock count |
| over_flag | output | 1 | No crossing in the last window |
| under_flag | output | 1 | Last result below `under_th` |

## Verification
The assertions assume that `run_hold` and `zc_in` are sampled cleanly at the rising clock. They also assume that `under_th` is steady around the edge that closes a window. The bench meets these conditions by changing every input only on the falling edge. It also holds the comparator flag high during zeroing and signal integration and releases it in the first reference clock. That stimulus loads the ignore rule and the crossing rule in the same conversion. Crossing positions and thresholds are drawn at random inside and just beyond the window. Fixed cases cover crossing at clock 0, crossing at the last clock, and thresholds equal to the result.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   typedef enum logic [2:0] {
      PH_PARK = 3'd0,
      PH_ZERO = 3'd1,
      PH_SIG  = 3'd2,
      PH_REF  = 3'd3,
      PH_PAD  = 3'd4
   } phase_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/dsc_phase_fsm.sv
module dsc_phase_fsm
   import dsc_pkg::*;
#(
   parameter int unsigned AZ_LEN = 10001,
   parameter int unsigned SI_LEN = 10000,
   parameter int unsigned CW     = 15
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   run_hold,
   input  logic   ref_cross,
   input  logic   win_last,
   output phase_e phase
);
   localparam logic [CW-1:0] ZERO_END = CW'(AZ_LEN - 1);
   localparam logic [CW-1:0] SIG_END  = CW'(SI_LEN - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_PARK;
         cnt   <= '0;
      end else begin
         case (phase)
            PH_PARK: begin
               cnt <= '0;
               if (run_hold) phase <= PH_ZERO;
            end
            PH_ZERO: begin
               if (cnt == ZERO_END) begin
                  phase <= PH_SIG;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_SIG: begin
               if (cnt == SIG_END) begin
                  phase <= PH_REF;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_REF, PH_PAD: begin
               cnt <= '0;
               if (win_last)                  phase <= run_hold ? PH_ZERO : PH_PARK;
               else if (phase == PH_REF && ref_cross) phase <= PH_PAD;
            end
            default: begin
               phase <= PH_PARK;
               cnt   <= '0;
            end
         endcase
      end
   end

   assert_park_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PARK && !run_hold) |=> phase == PH_PARK);
   assert_sig_after_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SIG && $past(phase) != PH_SIG) |-> $past(phase) == PH_ZERO);
   assert_zero_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ZERO) |-> cnt < CW'(AZ_LEN));
endmodule

// File: rtl/dsc_ref_window.sv
module dsc_ref_window
   import dsc_pkg::*;
#(
   parameter int unsigned RI_MAX  = 20001,
   parameter int unsigned ZC_SYNC = 2,
   parameter int unsigned CW      = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          zc_in,
   input  phase_e        phase,
   output logic          win_last,
   output logic          ref_cross,
   output logic [CW-1:0] wcnt,
   output logic [CW-1:0] cap_count,
   output logic          cap_hit
);
   localparam logic [CW-1:0] WIN_END = CW'(RI_MAX - 1);

   logic zc_s;
   logic win_act;

   generate
      if (ZC_SYNC == 0) begin : g_direct
         assign zc_s = zc_in;
      end else begin : g_sync
         logic [ZC_SYNC-1:0] sr;
         always_ff @(posedge clk) begin
            if (!rst_n) sr <= '0;
            else        sr <= (sr << 1) | ZC_SYNC'(zc_in);
         end
         assign zc_s = sr[ZC_SYNC-1];
      end
   endgenerate

   assign win_act   = (phase == PH_REF) || (phase == PH_PAD);
   assign win_last  = win_act && (wcnt == WIN_END);
   assign ref_cross = (phase == PH_REF) && zc_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt      <= '0;
         cap_count <= '0;
         cap_hit   <= 1'b0;
      end else if (!win_act) begin
         wcnt    <= '0;
         cap_hit <= 1'b0;
      end else begin
         wcnt <= wcnt + 1'b1;
         if (ref_cross) begin
            cap_hit   <= 1'b1;
            cap_count <= wcnt;
         end
      end
   end

   assert_win_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      win_act |-> wcnt < CW'(RI_MAX));
   assert_no_ref_after_cross_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PAD) |=> phase != PH_REF);
endmodule

// File: rtl/dsc_result_reg.sv
module dsc_result_reg #(
   parameter int unsigned RI_MAX = 20001,
   parameter int unsigned CW     = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          win_last,
   input  logic          ref_cross,
   input  logic [CW-1:0] wcnt,
   input  logic [CW-1:0] cap_count,
   input  logic          cap_hit,
   input  logic [CW-1:0] under_th,
   output logic          eom,
   output logic [CW-1:0] ref_count,
   output logic          over_flag,
   output logic          under_flag
);
   logic [CW-1:0] cnt_n;
   logic          ovr_n;

   always_comb begin
      if (ref_cross) begin
         cnt_n = wcnt;
         ovr_n = 1'b0;
      end else if (cap_hit) begin
         cnt_n = cap_count;
         ovr_n = 1'b0;
      end else begin
         cnt_n = CW'(RI_MAX);
         ovr_n = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eom        <= 1'b0;
         ref_count  <= '0;
         over_flag  <= 1'b0;
         under_flag <= 1'b0;
      end else begin
         eom <= win_last;
         if (win_last) begin
            ref_count  <= cnt_n;
            over_flag  <= ovr_n;
            under_flag <= !ovr_n && (cnt_n < under_th);
         end
      end
   end

   assert_eom_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eom |=> !eom);
   assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !eom |-> $stable(ref_count));
   assert_range_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(over_flag && under_flag));
   assert_over_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
      over_flag |-> ref_count == CW'(RI_MAX));
endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
   import dsc_pkg::*;
#(
   parameter int unsigned AZ_LEN  = 10001,
   parameter int unsigned SI_LEN  = 10000,
   parameter int unsigned RI_MAX  = 20001,
   parameter int unsigned ZC_SYNC = 2,
   localparam int unsigned CW     = $clog2(max3(AZ_LEN, SI_LEN, RI_MAX) + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_hold,
   input  logic          zc_in,
   input  logic [CW-1:0] under_th,
   output logic          az_sel,
   output logic          si_sel,
   output logic          ri_sel,
   output logic          busy,
   output logic          eom,
   output logic [CW-1:0] ref_count,
   output logic          over_flag,
   output logic          under_flag
);
   generate
      if (AZ_LEN < 1 || SI_LEN < 1 || RI_MAX < 2) begin : g_bad_len
         $error("dsc_sequencer: phase lengths too short");
      end
      if (ZC_SYNC > 4) begin : g_bad_sync
         $error("dsc_sequencer: ZC_SYNC above 4 is not supported");
      end
   endgenerate

   phase_e        phase;
   logic          win_last;
   logic          ref_cross;
   logic [CW-1:0] wcnt;
   logic [CW-1:0] cap_count;
   logic          cap_hit;

   dsc_phase_fsm #(
      .AZ_LEN(AZ_LEN), .SI_LEN(SI_LEN), .CW(CW)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .run_hold(run_hold),
      .ref_cross(ref_cross), .win_last(win_last), .phase(phase)
   );

   dsc_ref_window #(
      .RI_MAX(RI_MAX), .ZC_SYNC(ZC_SYNC), .CW(CW)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .zc_in(zc_in), .phase(phase),
      .win_last(win_last), .ref_cross(ref_cross), .wcnt(wcnt),
      .cap_count(cap_count), .cap_hit(cap_hit)
   );

   dsc_result_reg #(
      .RI_MAX(RI_MAX), .CW(CW)
   ) u_res (
      .clk(clk), .rst_n(rst_n), .win_last(win_last), .ref_cross(ref_cross),
      .wcnt(wcnt), .cap_count(cap_count), .cap_hit(cap_hit),
      .under_th(under_th), .eom(eom), .ref_count(ref_count),
      .over_flag(over_flag), .under_flag(under_flag)
   );

   assign az_sel = (phase == PH_PARK) || (phase == PH_ZERO) || (phase == PH_PAD);
   assign si_sel = (phase == PH_SIG);
   assign ri_sel = (phase == PH_REF);
   assign busy   = (phase == PH_SIG) || (phase == PH_REF) || (phase == PH_PAD);

   assert_one_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({az_sel, si_sel, ri_sel}));
   assert_busy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> eom);
   assert_eom_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eom |-> !busy);
   assert_sig_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(si_sel) |-> $rose(busy));
endmodule

// File: tb/dsc_sequencer_bench.sv
`timescale 1ns/1ps
module dsc_sequencer_bench;
   localparam int AZ = 11;
   localparam int SI = 10;
   localparam int RI = 21;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          run_hold;
   logic          zc_in;
   logic [CW-1:0] under_th;
   logic          az_sel, si_sel, ri_sel, busy, eom, over_flag, under_flag;
   logic [CW-1:0] ref_count;

   int     checks = 0;
   int     errors = 0;
   longint cyc = 0;
   longint last_eom = 0;
   int     prev_res = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dsc_sequencer #(.AZ_LEN(AZ), .SI_LEN(SI), .RI_MAX(RI), .ZC_SYNC(0)) u_dsc_sequencer (
      .clk(clk), .rst_n(rst_n), .run_hold(run_hold), .zc_in(zc_in),
      .under_th(under_th), .az_sel(az_sel), .si_sel(si_sel), .ri_sel(ri_sel),
      .busy(busy), .eom(eom), .ref_count(ref_count),
      .over_flag(over_flag), .under_flag(under_flag)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_count(input int k);
      return (k >= RI) ? RI : k;
   endfunction
   function automatic bit exp_over(input int k);
      return k >= RI;
   endfunction
   function automatic bit exp_under(input int k, input int th);
      return (k < RI) && (k < th);
   endfunction

   // starts in the first zeroing clock, ends in the eom clock
   task automatic run_conv(input int k, input int th, input bit chk_period, input bit drop_run);
      int n;
      under_th = CW'(th);
      zc_in = 1'b1;
      n = 0;
      while (!si_sel && n < 100) begin
         chk(busy == 1'b0 && az_sel == 1'b1, "R2", "zeroing outputs", busy, 0);
         n++;
         step();
         if (n == 1) chk(eom == 1'b0, "R6", "eom width", eom, 0);
      end
      chk(n == AZ, "R2", "zeroing length", n, AZ);
      n = 0;
      while (!ri_sel && n < 100) begin
         chk(busy == 1'b1, "R3", "busy in signal phase", busy, 1);
         if (drop_run && n == 0) run_hold = 1'b0;
         if (drop_run && n == 2) run_hold = 1'b1;
         if (drop_run && n == 3) run_hold = 1'b0;
         n++;
         step();
      end
      chk(n == SI, "R3", "signal length with comparator high", n, SI);
      for (int j = 0; j < RI; j++) begin
         chk(ri_sel == (j <= k), "R4", $sformatf("ri_sel at ref clock %0d", j), ri_sel, j <= k);
         chk(az_sel == (j > k) && busy, "R5", $sformatf("pad/busy at ref clock %0d", j), az_sel, j > k);
         if (j == RI - 1) chk(int'(ref_count) == prev_res, "R6", "result held before close", ref_count, prev_res);
         zc_in = (j >= k);
         step();
      end
      zc_in = 1'b0;
      chk(eom == 1'b1, "R6", "eom after window", eom, 1);
      chk(busy == 1'b0, "R6", "busy falls with eom", busy, 0);
      chk(int'(ref_count) == exp_count(k), (k >= RI) ? "R7" : "R4", "result count", ref_count, exp_count(k));
      chk(over_flag == exp_over(k), "R7", "over flag", over_flag, exp_over(k));
      chk(under_flag == exp_under(k, th), "R8", "under flag", under_flag, exp_under(k, th));
      if (chk_period) chk(cyc - last_eom == AZ + SI + RI, "R9", "conversion period", cyc - last_eom, AZ + SI + RI);
      last_eom = cyc;
      prev_res = exp_count(k);
   endtask

   task automatic check_parked(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         step();
         chk(az_sel && !si_sel && !ri_sel && !busy && !eom, "R10", "parked outputs", {az_sel, si_sel, ri_sel, busy}, 4'b1000);
         chk(int'(ref_count) == prev_res, "R10", "parked result", ref_count, prev_res);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; run_hold = 1'b0; zc_in = 1'b0; under_th = '0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk(az_sel && !si_sel && !ri_sel && !busy && !eom, "R1", "reset phase", {az_sel, si_sel, ri_sel, busy, eom}, 5'b10000);
      chk(ref_count == 0 && !over_flag && !under_flag, "R1", "reset result", ref_count, 0);
      check_parked(5);

      // R11 start from park, then free running (R9)
      run_hold = 1'b1;
      step();
      run_conv(0, 5, 1'b0, 1'b0);
      run_conv(RI - 1, 3, 1'b1, 1'b0);
      run_conv(RI, 3, 1'b1, 1'b0);
      run_conv(RI + 5, 30, 1'b1, 1'b0);
      run_conv(7, 7, 1'b1, 1'b0);
      run_conv(6, 7, 1'b1, 1'b0);
      for (int i = 0; i < 20; i++) begin
         run_conv(int'($urandom_range(RI + 3, 0)), int'($urandom_range(31, 0)), 1'b1, 1'b0);
      end

      // R10: drop run mid-conversion, pulse ignored, then park
      run_conv(9, 12, 1'b1, 1'b1);
      check_parked(12);

      // R11 single-shot runs
      for (int i = 0; i < 4; i++) begin
         run_hold = 1'b1;
         step();
         run_hold = 1'b0;
         run_conv(int'($urandom_range(RI + 2, 0)), int'($urandom_range(31, 0)), 1'b0, 1'b0);
         check_parked(6);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule